// File: doc/BRIEF.md
# Page Translation Lookaside Cache

This block keeps a small, fully associative set of recent page translations in front of a two-level table walker. A lookup brings in the 20-bit page number of a linear address, which is bits [31:12]; the 12-bit byte offset never enters the block. A lookup that finds its page resident returns the stored 20-bit frame number and the stored write-enable and user-access bits. It does so without touching the page tables. A lookup that does not find its page raises a walk request. The block then returns what the walker reports and keeps a copy of that result unless the walk faulted.

Lookups and responses use valid/ready handshakes. A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is high only while no lookup is in progress, so at most one lookup is in flight. The response holds `rsp_valid` and every response field steady until `rsp_ready` is seen high at a clock edge. The walk request holds in the same way until `walk_req_ready`. The walker's answer arrives as a single-cycle `walk_rsp_valid` pulse with no ready. Two plain control inputs empty the whole cache. `base_wr` empties it on every write of the directory base. `ctx_sw` empties it only when the directory base it loads differs from the one held.

Top module: `xlat_cache`

## Requirements
- R1: `req_ready` is high only when no lookup is in progress. While a response is pending, `rsp_valid` and `rsp_pfn`/`rsp_rw`/`rsp_us`/`rsp_fault` hold steady until `rsp_ready` is high at a clock edge. `req_ready` is low during a walk.
- R2: A lookup whose page number matches a valid entry answers with that entry's frame number, write-enable and user bits and `rsp_fault`=0. It makes no walk request.
- R3: A lookup with no matching entry raises `walk_req_valid` carrying the same page number and write flag. The request holds until `walk_req_ready`. The response then carries the walker's frame, bits and fault flag.
- R4: The cache holds 8 entries. A non-faulting walk result for a page not resident is written into the slot under a round-robin pointer, and the pointer then advances. After 8 distinct fills, a 9th distinct page evicts the earliest filled one.
- R5: A walk result with `walk_rsp_fault`=1 is returned but not installed, so the same page misses again.
- R6: Each entry records whether its dirty flag is already set in memory. A write lookup that hits an entry without that record is handled as a miss. The walker's `walk_rsp_dirty` is then stored into that same entry, and the round-robin pointer does not move.
- R7: Every `base_wr` pulse invalidates all entries from the next cycle on, even when the written value equals the held one.
- R8: A `ctx_sw` pulse invalidates all entries only when `ctx_sw_base` differs from the held directory base. Either input loads the held base, and `base_wr` takes priority.
- R9: An invalidation in the same cycle as a walk result, or while that walk is outstanding, prevents the result from being installed. The result is still returned on the response port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_vpn | input | 20 | Page number (linear address bits [31:12]) |
| req_write | input | 1 | Lookup is for a write access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_pfn | output | 20 | Frame number |
| rsp_rw | output | 1 | Write-enable bit of the translation |
| rsp_us | output | 1 | User-access bit of the translation |
| rsp_fault | output | 1 | Walker reported a fault |
| walk_req_valid | output | 1 | Walk request valid |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_vpn | output | 20 | Page number to walk |
| walk_write | output | 1 | Walk is for a write access |
| walk_rsp_valid | input | 1 | Walker result pulse |
| walk_rsp_pfn | input | 20 | Walked frame number |
| walk_rsp_rw | input | 1 | Walked write-enable bit |
| walk_rsp_us | input | 1 | Walked user-access bit |
| walk_rsp_dirty | input | 1 | Dirty flag is set in memory |
| walk_rsp_fault | input | 1 | Walk faulted |
| base_wr | input | 1 | Directory base write pulse |
| base_wr_data | input | 20 | Value written |
| ctx_sw | input | 1 | Context switch base load pulse |
| ctx_sw_base | input | 20 | Base loaded by the context switch |

## Verification
The hardest case to reach is an invalidation in the very cycle the walker's result arrives. From the ports that case is indistinguishable from a normal fill unless the same page is looked up again afterwards. The stimulus drives `base_wr` together with the `walk_rsp_valid` pulse, then repeats the lookup and expects a second walk. The refresh-in-place path of R6 is reached by filling all eight slots with read lookups, writing to a resident page, and then showing that the next new page still evicts the oldest slot. A long read-only sweep with a repeating page pattern is compared against an arithmetic first-in-first-out occupancy model.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
  typedef enum logic [2:0] {
    XC_IDLE = 3'd0,
    XC_LOOK = 3'd1,
    XC_WALK = 3'd2,
    XC_WAIT = 3'd3,
    XC_RESP = 3'd4
  } xc_state_e;
endpackage

// File: rtl/xlat_cache_tags.sv
module xlat_cache_tags #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PFN_W-1:0]   fill_pfn,
  input  logic               fill_rw,
  input  logic               fill_us,
  input  logic               fill_dty,
  input  logic [VPN_W-1:0]   look_vpn,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [PFN_W-1:0]   hit_pfn,
  output logic               hit_rw,
  output logic               hit_us,
  output logic               hit_dty,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] match_vec
);
  logic [VPN_W-1:0] tag_vec [ENTRIES];
  logic [PFN_W-1:0] pfn_vec [ENTRIES];
  logic [ENTRIES-1:0] rw_vec, us_vec, dty_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             vld_r;
    logic [VPN_W-1:0] tag_r;
    logic [PFN_W-1:0] pfn_r;
    logic             rw_r, us_r, dty_r;
    logic             wr_here;

    assign wr_here = fill_en && (fill_idx == IDX_W'(g));

    // invalidation outranks a fill landing in the same cycle
    always_ff @(posedge clk) begin
      if (!rst_n)        vld_r <= 1'b0;
      else if (flush)    vld_r <= 1'b0;
      else if (wr_here)  vld_r <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_r <= '0;
        pfn_r <= '0;
        rw_r  <= 1'b0;
        us_r  <= 1'b0;
        dty_r <= 1'b0;
      end else if (wr_here && !flush) begin
        tag_r <= fill_vpn;
        pfn_r <= fill_pfn;
        rw_r  <= fill_rw;
        us_r  <= fill_us;
        dty_r <= fill_dty;
      end
    end

    assign valid_vec[g] = vld_r;
    assign match_vec[g] = vld_r && (tag_r == look_vpn);
    assign tag_vec[g]   = tag_r;
    assign pfn_vec[g]   = pfn_r;
    assign rw_vec[g]    = rw_r;
    assign us_vec[g]    = us_r;
    assign dty_vec[g]   = dty_r;
  end

  assign hit = |match_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

  assign hit_pfn = pfn_vec[hit_idx];
  assign hit_rw  = rw_vec[hit_idx];
  assign hit_us  = us_vec[hit_idx];
  assign hit_dty = dty_vec[hit_idx];
endmodule

// File: rtl/xlat_cache_victim.sv
module xlat_cache_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/xlat_cache_ctrl.sv
module xlat_cache_ctrl
  import xlat_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             req_write,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             rsp_rw,
  output logic             rsp_us,
  output logic             rsp_fault,
  output logic             walk_req_valid,
  input  logic             walk_req_ready,
  output logic [VPN_W-1:0] walk_vpn,
  output logic             walk_write,
  input  logic             walk_rsp_valid,
  input  logic [PFN_W-1:0] walk_rsp_pfn,
  input  logic             walk_rsp_rw,
  input  logic             walk_rsp_us,
  input  logic             walk_rsp_dirty,
  input  logic             walk_rsp_fault,
  output logic [VPN_W-1:0] look_vpn,
  input  logic             hit,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic [PFN_W-1:0] hit_pfn,
  input  logic             hit_rw,
  input  logic             hit_us,
  input  logic             hit_dty,
  input  logic [IDX_W-1:0] victim,
  output logic             fill_en,
  output logic [IDX_W-1:0] fill_idx,
  output logic             advance
);
  xc_state_e        st_q;
  logic [VPN_W-1:0] vpn_q;
  logic             wr_q;
  logic             resident_q;
  logic [IDX_W-1:0] res_idx_q;
  logic             stale_q;
  logic             use_hit;
  logic             take_walk;

  assign look_vpn       = vpn_q;
  assign req_ready      = (st_q == XC_IDLE);
  assign rsp_valid      = (st_q == XC_RESP);
  assign walk_req_valid = (st_q == XC_WALK);
  assign walk_vpn       = vpn_q;
  assign walk_write     = wr_q;

  // a write to a page whose dirty flag is not yet recorded must reach the walker
  assign use_hit   = hit && !(wr_q && !hit_dty);
  assign take_walk = (st_q == XC_WAIT) && walk_rsp_valid;

  assign fill_en  = take_walk && !walk_rsp_fault && !stale_q && !flush;
  assign fill_idx = resident_q ? res_idx_q : victim;
  assign advance  = fill_en && !resident_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= XC_IDLE;
      vpn_q      <= '0;
      wr_q       <= 1'b0;
      resident_q <= 1'b0;
      res_idx_q  <= '0;
      stale_q    <= 1'b0;
      rsp_pfn    <= '0;
      rsp_rw     <= 1'b0;
      rsp_us     <= 1'b0;
      rsp_fault  <= 1'b0;
    end else begin
      unique case (st_q)
        XC_IDLE: begin
          if (req_valid) begin
            vpn_q <= req_vpn;
            wr_q  <= req_write;
            st_q  <= XC_LOOK;
          end
        end
        XC_LOOK: begin
          if (use_hit) begin
            rsp_pfn   <= hit_pfn;
            rsp_rw    <= hit_rw;
            rsp_us    <= hit_us;
            rsp_fault <= 1'b0;
            st_q      <= XC_RESP;
          end else begin
            resident_q <= hit;
            res_idx_q  <= hit_idx;
            stale_q    <= flush;
            st_q       <= XC_WALK;
          end
        end
        XC_WALK: begin
          if (flush) stale_q <= 1'b1;
          if (walk_req_ready) st_q <= XC_WAIT;
        end
        XC_WAIT: begin
          if (flush) stale_q <= 1'b1;
          if (walk_rsp_valid) begin
            rsp_pfn   <= walk_rsp_pfn;
            rsp_rw    <= walk_rsp_rw;
            rsp_us    <= walk_rsp_us;
            rsp_fault <= walk_rsp_fault;
            st_q      <= XC_RESP;
          end
        end
        XC_RESP: begin
          if (rsp_ready) st_q <= XC_IDLE;
        end
        default: st_q <= XC_IDLE;
      endcase
    end
  end

  logic unused_dirty;
  assign unused_dirty = walk_rsp_dirty;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             req_write,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             rsp_rw,
  output logic             rsp_us,
  output logic             rsp_fault,
  output logic             walk_req_valid,
  input  logic             walk_req_ready,
  output logic [VPN_W-1:0] walk_vpn,
  output logic             walk_write,
  input  logic             walk_rsp_valid,
  input  logic [PFN_W-1:0] walk_rsp_pfn,
  input  logic             walk_rsp_rw,
  input  logic             walk_rsp_us,
  input  logic             walk_rsp_dirty,
  input  logic             walk_rsp_fault,
  input  logic             base_wr,
  input  logic [PFN_W-1:0] base_wr_data,
  input  logic             ctx_sw,
  input  logic [PFN_W-1:0] ctx_sw_base
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [PFN_W-1:0]   base_q;
  logic               flush;
  logic [VPN_W-1:0]   look_vpn;
  logic               hit, hit_rw, hit_us, hit_dty;
  logic [IDX_W-1:0]   hit_idx, victim, fill_idx;
  logic [PFN_W-1:0]   hit_pfn;
  logic               fill_en, advance;
  logic [ENTRIES-1:0] valid_vec, match_vec;

  assign flush = base_wr || (ctx_sw && (ctx_sw_base != base_q));

  always_ff @(posedge clk) begin
    if (!rst_n)       base_q <= '0;
    else if (base_wr) base_q <= base_wr_data;
    else if (ctx_sw)  base_q <= ctx_sw_base;
  end

  xlat_cache_tags #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(look_vpn),
    .fill_pfn(walk_rsp_pfn), .fill_rw(walk_rsp_rw), .fill_us(walk_rsp_us),
    .fill_dty(walk_rsp_dirty), .look_vpn(look_vpn),
    .hit(hit), .hit_idx(hit_idx), .hit_pfn(hit_pfn), .hit_rw(hit_rw),
    .hit_us(hit_us), .hit_dty(hit_dty), .valid_vec(valid_vec), .match_vec(match_vec)
  );

  xlat_cache_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .advance(advance), .ptr(victim)
  );

  xlat_cache_ctrl #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pfn(rsp_pfn), .rsp_rw(rsp_rw),
    .rsp_us(rsp_us), .rsp_fault(rsp_fault),
    .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready),
    .walk_vpn(walk_vpn), .walk_write(walk_write),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pfn(walk_rsp_pfn),
    .walk_rsp_rw(walk_rsp_rw), .walk_rsp_us(walk_rsp_us),
    .walk_rsp_dirty(walk_rsp_dirty), .walk_rsp_fault(walk_rsp_fault),
    .look_vpn(look_vpn), .hit(hit), .hit_idx(hit_idx), .hit_pfn(hit_pfn),
    .hit_rw(hit_rw), .hit_us(hit_us), .hit_dty(hit_dty), .victim(victim),
    .fill_en(fill_en), .fill_idx(fill_idx), .advance(advance)
  );
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [PFN_W-1:0]   rsp_pfn,
  input logic               walk_req_valid,
  input logic               walk_req_ready,
  input logic [VPN_W-1:0]   walk_vpn,
  input logic               walk_rsp_valid,
  input logic               walk_rsp_fault,
  input logic               flush,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] match_vec
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pfn)); // R1
  AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !walk_req_valid); // R1
  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid && !walk_req_ready |=> walk_req_valid && $stable(walk_vpn)); // R3
  AST_FAULT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    walk_rsp_valid && walk_rsp_fault |=> $countones(valid_vec) <= $countones($past(valid_vec))); // R5
  AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_vec == '0); // R7
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_pfn(rsp_pfn), .walk_req_valid(walk_req_valid),
  .walk_req_ready(walk_req_ready), .walk_vpn(walk_vpn), .walk_rsp_valid(walk_rsp_valid),
  .walk_rsp_fault(walk_rsp_fault), .flush(flush), .valid_vec(valid_vec),
  .match_vec(match_vec)
);

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_vpn = '0;
  logic        req_ready, rsp_valid, rsp_rw, rsp_us, rsp_fault;
  logic        rsp_ready = 1'b1;
  logic [19:0] rsp_pfn, walk_vpn;
  logic        walk_req_valid, walk_write;
  logic        walk_req_ready = 1'b1;
  logic        walk_rsp_valid = 1'b0, walk_rsp_rw = 1'b0, walk_rsp_us = 1'b0;
  logic        walk_rsp_dirty = 1'b0, walk_rsp_fault = 1'b0;
  logic [19:0] walk_rsp_pfn = '0;
  logic        base_wr = 1'b0, ctx_sw = 1'b0;
  logic [19:0] base_wr_data = '0, ctx_sw_base = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  xlat_cache u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_pfn(rsp_pfn), .rsp_rw(rsp_rw), .rsp_us(rsp_us),
    .rsp_fault(rsp_fault), .walk_req_valid(walk_req_valid),
    .walk_req_ready(walk_req_ready), .walk_vpn(walk_vpn), .walk_write(walk_write),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pfn(walk_rsp_pfn),
    .walk_rsp_rw(walk_rsp_rw), .walk_rsp_us(walk_rsp_us),
    .walk_rsp_dirty(walk_rsp_dirty), .walk_rsp_fault(walk_rsp_fault),
    .base_wr(base_wr), .base_wr_data(base_wr_data), .ctx_sw(ctx_sw),
    .ctx_sw_base(ctx_sw_base)
  );

  function automatic logic [19:0] pfn_of(input logic [19:0] v);
    return v * 20'd37 + 20'h0BEEF;
  endfunction

  function automatic logic [19:0] page(input int i);
    return 20'h40000 + 20'(i) * 20'h111;
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // one lookup; bench plays the walker
  task automatic look(input logic [19:0] v, input bit wr, input bit flt, input bit fl_on_rsp,
                      input int hold, input string rq, output bit walked);
    logic [19:0] got_pfn;
    bit got_rw, got_us, got_f;
    bit seen;
    walked = 1'b0;
    seen = 1'b0;
    got_pfn = '0; got_rw = 1'b0; got_us = 1'b0; got_f = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vpn = v; req_write = wr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      if (walk_req_valid && !walked) begin
        walked = 1'b1;
        chk("R3", "walk page", 32'(walk_vpn), 32'(v));
        chk("R3", "walk write flag", 32'(walk_write), 32'(wr));
        chk("R1", "ready low during walk", 32'(req_ready), 32'd0);
        @(negedge clk);
        walk_rsp_valid = 1'b1; walk_rsp_pfn = pfn_of(v);
        walk_rsp_rw = v[0]; walk_rsp_us = v[2]; walk_rsp_dirty = wr;
        walk_rsp_fault = flt; base_wr = fl_on_rsp; base_wr_data = '0;
        @(negedge clk);
        walk_rsp_valid = 1'b0; walk_rsp_fault = 1'b0; base_wr = 1'b0;
      end
      if (rsp_valid) begin
        seen = 1'b1;
        got_pfn = rsp_pfn; got_rw = rsp_rw; got_us = rsp_us; got_f = rsp_fault;
      end else begin
        @(negedge clk);
      end
    end
    chk(rq, "response seen", 32'(seen), 32'd1);
    chk(rq, "frame", 32'(got_pfn), 32'(pfn_of(v)));
    chk(rq, "rw/us", {30'd0, got_rw, got_us}, {30'd0, v[0], v[2]});
    chk(rq, "fault", 32'(got_f), 32'(flt));
    if (hold > 0) begin
      rsp_ready = 1'b0;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk("R1", "rsp held valid", 32'(rsp_valid), 32'd1);
        chk("R1", "rsp frame stable", 32'(rsp_pfn), 32'(got_pfn));
      end
      rsp_ready = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic pulse_base(input logic [19:0] d);
    @(negedge clk); base_wr = 1'b1; base_wr_data = d;
    @(negedge clk); base_wr = 1'b0;
  endtask

  task automatic pulse_ctx(input logic [19:0] d);
    @(negedge clk); ctx_sw = 1'b1; ctx_sw_base = d;
    @(negedge clk); ctx_sw = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    bit w;
    logic [19:0] fifo [8];
    int cnt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset req_ready", 32'(req_ready), 32'd1);
    chk("R1", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R3", "reset walk_req_valid", 32'(walk_req_valid), 32'd0);

    look(page(0), 1'b0, 1'b0, 1'b0, 0, "R3", w);
    chk("R3", "first lookup walks", 32'(w), 32'd1);
    look(page(0), 1'b0, 1'b0, 1'b0, 0, "R2", w);
    chk("R2", "resident lookup no walk", 32'(w), 32'd0);

    for (int i = 1; i < 8; i++) begin
      look(page(i), 1'b0, 1'b0, 1'b0, 0, "R4", w);
      chk("R4", "fill walk", 32'(w), 32'd1);
    end
    for (int i = 0; i < 8; i++) begin
      look(page(i), 1'b0, 1'b0, 1'b0, 0, "R2", w);
      chk("R4", "all eight resident", 32'(w), 32'd0);
    end

    look(page(3), 1'b1, 1'b0, 1'b0, 0, "R6", w);
    chk("R6", "write without dirty walks", 32'(w), 32'd1);
    look(page(3), 1'b1, 1'b0, 1'b0, 0, "R6", w);
    chk("R6", "write after dirty record hits", 32'(w), 32'd0);

    look(page(8), 1'b0, 1'b0, 1'b0, 0, "R4", w);
    chk("R4", "ninth page walks", 32'(w), 32'd1);
    look(page(3), 1'b0, 1'b0, 1'b0, 0, "R6", w);
    chk("R6", "refreshed page kept, pointer unmoved", 32'(w), 32'd0);
    look(page(1), 1'b0, 1'b0, 1'b0, 0, "R4", w);
    chk("R4", "second oldest kept", 32'(w), 32'd0);
    look(page(0), 1'b0, 1'b0, 1'b0, 0, "R4", w);
    chk("R4", "oldest evicted", 32'(w), 32'd1);

    look(page(9), 1'b0, 1'b1, 1'b0, 0, "R5", w);
    chk("R5", "faulting walk", 32'(w), 32'd1);
    look(page(9), 1'b0, 1'b0, 1'b0, 0, "R5", w);
    chk("R5", "fault not installed", 32'(w), 32'd1);

    pulse_base(20'h0);
    look(page(3), 1'b0, 1'b0, 1'b0, 0, "R7", w);
    chk("R7", "same-value base write flushes", 32'(w), 32'd1);

    pulse_ctx(20'h0);
    look(page(3), 1'b0, 1'b0, 1'b0, 0, "R8", w);
    chk("R8", "same base context switch keeps", 32'(w), 32'd0);
    pulse_ctx(20'h5);
    look(page(3), 1'b0, 1'b0, 1'b0, 0, "R8", w);
    chk("R8", "new base context switch flushes", 32'(w), 32'd1);

    look(page(10), 1'b0, 1'b0, 1'b1, 0, "R9", w);
    chk("R9", "walk with coincident flush", 32'(w), 32'd1);
    look(page(10), 1'b0, 1'b0, 1'b0, 0, "R9", w);
    chk("R9", "flushed result not installed", 32'(w), 32'd1);

    look(page(10), 1'b0, 1'b0, 1'b0, 3, "R1", w);
    chk("R1", "held response was a hit", 32'(w), 32'd0);

    // read-only sweep against a first-in-first-out occupancy model (R4, R2)
    pulse_base(20'h7);
    cnt = 0;
    for (int s = 0; s < 150; s++) begin
      logic [19:0] v;
      bit inm;
      v = 20'h00100 + 20'((s * 5) % 13);
      inm = 1'b0;
      for (int k = 0; k < cnt; k++) if (fifo[k] == v) inm = 1'b1;
      look(v, 1'b0, 1'b0, 1'b0, 0, "R4", w);
      chk("R4", "sweep walk decision", 32'(w), 32'(!inm));
      if (!inm) begin
        if (cnt == 8) begin
          for (int k = 0; k < 7; k++) fifo[k] = fifo[k+1];
          fifo[7] = v;
        end else begin
          fifo[cnt] = v;
          cnt++;
        end
      end
    end

    finish_up();
  end
endmodule